// File: doc/BRIEF.md
# Edge Capture Flag Bank

This block watches a bank of digital inputs and remembers which channels have seen an edge. Each input is registered once per clock, and an edge is found by comparing the new sample with the previous one. A two-bit mode per channel chooses what counts as an event: rising transitions, falling transitions, both, or none. A qualifying edge sets a sticky capture flag for that channel. Once a flag is set, later edges on that channel leave no trace until the flag is consumed.

A host consumes the flags by pulsing a read strobe. In that cycle the flag vector on the output is the returned value, and at the next clock edge every flag is cleared. The channel modes are left as they were, so capturing continues. An edge found in the same cycle as the read is kept, so it is not lost.

A waiter supplies a channel mask and a mode bit. The event output is high when any masked flag is set, or when every masked flag is set. In the every-flag mode an empty mask never raises the event.

Top module: `edgecap_bank`

## Requirements
- R1: Channel c takes its mode from bits [2c+1:2c] of `mode_i`. 00 disables capture, 01 captures rising edges (0 to 1), 10 captures falling edges (1 to 0), and 11 captures both. A disabled channel never sets its flag.
- R2: An input change that is stable before clock edge k is sampled at edge k. If the mode selects it, it shows on `flags_o` after edge k+1.
- R3: A set flag stays set until a read. An edge that arrives while the flag is set changes nothing and is not counted.
- R4: While `rd_i` is high, `flags_o` is the value being returned. At the next clock edge all flags clear, and the channel modes keep capturing later edges.
- R5: A qualifying edge detected in the same cycle as `rd_i` leaves that channel's flag set after the edge.
- R6: Changing `mode_i` never clears a flag that is already set.
- R7: After reset all flags are 0. The first sample taken after reset produces no edge, whatever the input level.
- R8: With `wait_all_i` = 0, `event_o` is 1 exactly when at least one flag selected by `wait_mask_i` is set. It follows `flags_o` in the same cycle.
- R9: With `wait_all_i` = 1, `event_o` is 1 exactly when the mask is non-empty and every masked flag is set. An all-zero mask gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | N | Digital inputs, one per channel |
| mode_i | input | 2*N | Per-channel capture mode fields |
| rd_i | input | 1 | Host read strobe; clears all flags at the next edge |
| flags_o | output | N | Capture flags, also the read data |
| wait_mask_i | input | N | Channels selected for the event match |
| wait_all_i | input | 1 | 0: match on any masked flag; 1: match on all masked flags |
| event_o | output | 1 | Match result of flags against the mask |

## Verification
An input change made before clock edge k reaches the flags after edge k+1. This is one sample register plus the flag register. `event_o` follows the flags with no further delay. A read strobe takes effect at the edge that ends its cycle. A reference model in the bench steps once per clock edge and queues the flags and event it expects after that edge. A monitor compares them a few nanoseconds after the same edge, and the driver changes inputs only on the falling edge, so every comparison lands in the cycle where the result is due.

// File: rtl/edgecap_pkg.sv
package edgecap_pkg;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_BOTH = 2'b11
  } cap_mode_e;

  function automatic logic edge_hit(input cap_mode_e md, input logic cur, input logic prv);
    logic rise;
    logic fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    case (md)
      CAP_RISE: edge_hit = rise;
      CAP_FALL: edge_hit = fall;
      CAP_BOTH: edge_hit = rise | fall;
      default:  edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/edgecap_rst_sync.sv
module edgecap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/edgecap_sampler.sv
module edgecap_sampler #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o,
  output logic         valid_o
);
  logic [N-1:0] cur_q, cur_d;
  logic [N-1:0] prev_q, prev_d;
  logic         got1_q, got1_d;
  logic         got2_q, got2_d;

  // Next-state: shift the sample history; the valid pair only after two samples.
  always_comb begin
    cur_d  = pin_i;
    prev_d = cur_q;
    got1_d = 1'b1;
    got2_d = got1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      got1_q <= 1'b0;
      got2_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
      got1_q <= got1_d;
      got2_q <= got2_d;
    end
  end

  assign cur_o   = cur_q;
  assign prev_o  = prev_q;
  assign valid_o = got2_q;
endmodule

// File: rtl/edgecap_flags.sv
module edgecap_flags
  import edgecap_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   cur_i,
  input  logic [N-1:0]   prev_i,
  input  logic           valid_i,
  input  logic [2*N-1:0] mode_i,
  input  logic           rd_i,
  output logic [N-1:0]   flags_o
);
  for (genvar c = 0; c < N; c++) begin : g_chan
    cap_mode_e md;
    logic      hit;
    logic      flag_q, flag_d, flag_en;

    assign md  = cap_mode_e'(mode_i[2*c +: 2]);
    assign hit = valid_i & edge_hit(md, cur_i[c], prev_i[c]);

    // A read drops the flag unless an edge lands in the same cycle.
    always_comb begin
      flag_en = rd_i | hit;
      flag_d  = hit | (flag_q & ~rd_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end

    assign flags_o[c] = flag_q;
  end
endmodule

// File: rtl/edgecap_match.sv
module edgecap_match #(
  parameter int N = 8
) (
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] mask_i,
  input  logic         all_i,
  output logic         event_o
);
  logic [N-1:0] sel;
  logic         any_hit;
  logic         all_hit;

  always_comb begin
    sel     = flags_i & mask_i;
    any_hit = |sel;
    all_hit = (|mask_i) && (sel == mask_i);
    event_o = all_i ? all_hit : any_hit;
  end
endmodule

// File: rtl/edgecap_bank.sv
module edgecap_bank #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   pin_i,
  input  logic [2*N-1:0] mode_i,
  input  logic           rd_i,
  output logic [N-1:0]   flags_o,
  input  logic [N-1:0]   wait_mask_i,
  input  logic           wait_all_i,
  output logic           event_o
);
  logic         rst_sn;
  logic [N-1:0] cur;
  logic [N-1:0] prev;
  logic         valid;

  edgecap_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  edgecap_sampler #(.N(N)) u_smp (
    .clk     (clk),
    .rst_n   (rst_sn),
    .pin_i   (pin_i),
    .cur_o   (cur),
    .prev_o  (prev),
    .valid_o (valid)
  );

  edgecap_flags #(.N(N)) u_flg (
    .clk     (clk),
    .rst_n   (rst_sn),
    .cur_i   (cur),
    .prev_i  (prev),
    .valid_i (valid),
    .mode_i  (mode_i),
    .rd_i    (rd_i),
    .flags_o (flags_o)
  );

  edgecap_match #(.N(N)) u_mt (
    .flags_i (flags_o),
    .mask_i  (wait_mask_i),
    .all_i   (wait_all_i),
    .event_o (event_o)
  );
endmodule

// File: rtl/edgecap_bank_chk.sv
module edgecap_bank_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*N-1:0] mode_i,
  input logic           rd_i,
  input logic [N-1:0]   flags_o,
  input logic [N-1:0]   wait_mask_i,
  input logic           wait_all_i,
  input logic           event_o
);
  logic [1:0] boot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           boot_q <= '0;
    else if (boot_q != 3) boot_q <= boot_q + 2'd1;
  end

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (($past(flags_o) & ~flags_o) == '0));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && mode_i == '0) |=> (flags_o == '0));

  p_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == '0) |=> ((flags_o & ~$past(flags_o)) == '0));

  p_boot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_q != 3) |-> (flags_o == '0));

  p_anyreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_all_i && (flags_o & wait_mask_i) != '0) |-> event_o);

  p_evsrc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> ((flags_o & wait_mask_i) != '0));

  p_allempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_all_i && wait_mask_i == '0) |-> !event_o);
endmodule

bind edgecap_bank edgecap_bank_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sn),
  .mode_i      (mode_i),
  .rd_i        (rd_i),
  .flags_o     (flags_o),
  .wait_mask_i (wait_mask_i),
  .wait_all_i  (wait_all_i),
  .event_o     (event_o)
);

// File: tb/test_edgecap_bank.sv
`timescale 1ns/1ps
module test_edgecap_bank;
  localparam int N = 8;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   pin_i;
  logic [2*N-1:0] mode_i;
  logic           rd_i;
  logic [N-1:0]   flags_o;
  logic [N-1:0]   wait_mask_i;
  logic           wait_all_i;
  logic           event_o;

  edgecap_bank #(.N(N)) i_edgecap_bank (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mode_i(mode_i), .rd_i(rd_i),
    .flags_o(flags_o), .wait_mask_i(wait_mask_i), .wait_all_i(wait_all_i),
    .event_o(event_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [N-1:0] flags;
    logic         ev;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // reference state
  logic [N-1:0] m_cur, m_prev, m_flags;

  function automatic logic m_event(logic [N-1:0] f, logic [N-1:0] m, logic a);
    if (a) return (m != 0) && ((f & m) == m);
    return (f & m) != 0;
  endfunction

  task automatic step(input logic [N-1:0] p, input logic [2*N-1:0] md, input logic rd,
                      input logic [N-1:0] msk, input logic all, input string tag);
    logic [N-1:0] hit;
    exp_t e;
    @(negedge clk);
    pin_i = p; mode_i = md; rd_i = rd; wait_mask_i = msk; wait_all_i = all;
    @(posedge clk);
    for (int c = 0; c < N; c++) begin
      logic r, f;
      r = m_cur[c] & ~m_prev[c];
      f = ~m_cur[c] & m_prev[c];
      hit[c] = (md[2*c] & r) | (md[2*c+1] & f);
    end
    m_flags = (rd ? '0 : m_flags) | hit;
    m_prev  = m_cur;
    m_cur   = p;
    e.flags = m_flags;
    e.ev    = m_event(m_flags, msk, all);
    e.tag   = tag;
    #1 exp_q.push_back(e);
  endtask

  // monitor: compares a few ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (flags_o !== e.flags || event_o !== e.ev) begin
          n_bad++;
          $display("FAIL %s: flags=%h event=%b expected flags=%h event=%b",
                   e.tag, flags_o, event_o, e.flags, e.ev);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  localparam logic [2*N-1:0] MIX = 16'hFF39; // ch0 rise, ch1 fall, ch2 both, ch3 off, ch4-7 both

  initial begin
    logic [N-1:0] lf;
    rst_n = 1'b0; pin_i = '1; mode_i = MIX; rd_i = 0; wait_mask_i = '0; wait_all_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    m_cur = '1; m_prev = '1; m_flags = '0;
    // R7: input held high across reset, no edge from first sample
    repeat (5) step('1, MIX, 0, '0, 0, "R7");
    // R1/R2: falling on all channels
    step('0, MIX, 0, 8'h06, 0, "R2");
    step('0, MIX, 0, 8'h06, 0, "R2");
    step('0, MIX, 0, 8'h06, 1, "R9");
    step('0, MIX, 1, 8'h08, 1, "R4");
    step('0, MIX, 0, 8'h08, 0, "R4");
    // R1: rising
    step('1, MIX, 0, 8'h00, 1, "R1");
    step('1, MIX, 0, 8'h00, 1, "R9");
    step('1, MIX, 0, 8'h05, 1, "R9");
    // R3: edges while set are lost
    step('0, MIX, 0, 8'h05, 0, "R3");
    step('0, MIX, 0, 8'h05, 0, "R3");
    step('0, MIX, 1, 8'h02, 0, "R8");
    step('0, MIX, 0, 8'h02, 0, "R3");
    step('0, MIX, 0, 8'h02, 0, "R3");
    // R5: edge coincides with read
    step('1, MIX, 0, 8'hF0, 1, "R5");
    step('1, MIX, 1, 8'hF0, 1, "R5");
    step('1, MIX, 0, 8'hF0, 1, "R5");
    // R6: mode change keeps flags
    step('1, '0, 0, 8'hF0, 0, "R6");
    step('0, '0, 0, 8'hF0, 0, "R6");
    step('1, '0, 0, 8'hF0, 0, "R6");
    step('1, '0, 1, 8'h00, 1, "R4");
    step('1, '0, 0, 8'h00, 1, "R9");
    // mixed patterns
    lf = 8'h5A;
    for (int i = 0; i < 200; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf, (i % 3 == 0) ? 16'hE4B1 : MIX, (i % 5 == 4), ~lf, i[2], "R2");
    end
    repeat (2) @(posedge clk);
    #8;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule